// File: doc/BRIEF.md
# Orderly Halt Sequencer

When an interrupt asks the script processor to stop, this block decides how far the work in progress may run before the stop is reported. It captures the kind of activity in progress when the request arrives: an instruction fetch, a data transfer, a transfer-control instruction, or some other instruction. It then walks one wait path for that activity. After that it waits until the SCSI bus side is quiet and emits a one-cycle halted pulse. A bus fault overrides every wait path.

While a halt is pending, and until the interrupt request is withdrawn, `exec_hold` keeps the processor from starting another instruction. The fetched instruction is therefore never executed. The instruction pointer already points past it, so no pointer update is issued for a fetch. A conditional jump or call that tests the bus phase gets one `ip_load` strobe, which loads the target address before the halt.

The states are:
- S_RUN: idle.
- S_FETCH_WAIT: waiting for `fetch_done`.
- S_FLUSH: a SCSI interrupt arrived during a write to memory, so the block waits for the DMA FIFO to empty.
- S_CYCLE_WAIT: any other transfer, which waits for `cycle_done`.
- S_TCI_WAIT: waiting for `tci_done`.
- S_IP_LOAD: a one-cycle pointer strobe.
- S_DRAIN: waiting until there is no handshake and no synchronous offset.
- S_HALT: the pulse.
- S_STOPPED: waiting for the request to drop.

The transitions are:
- S_RUN to a wait state, or to S_DRAIN, or to S_HALT on a fault.
- Each wait state to S_DRAIN when its completion arrives, or to S_HALT on a fault.
- S_TCI_WAIT to S_IP_LOAD on a phase jump.
- S_IP_LOAD to S_DRAIN.
- S_DRAIN to S_HALT.
- S_HALT to S_STOPPED.
- S_STOPPED to S_RUN.

Top module: `halt_seq`

## Requirements
- R1: After reset `flush_req`, `ip_load`, `halted` and `exec_hold` are all low.
- R2: `exec_hold` is high from the cycle after an interrupt request is accepted in the run state until the cycle after `irq_req` is seen low in the stopped state.
- R3: With `activity` = 2'b00 (fetch), the block waits for `fetch_done` before draining and never pulses `ip_load`.
- R4: With `activity` = 2'b01 (transfer), `irq_scsi` high and `dma_wr_mem` high, `flush_req` stays high from the cycle after acceptance until `dma_fifo_empty` is seen.
- R5: With `activity` = 2'b01 and either `irq_scsi` or `dma_wr_mem` low, the block only waits for `cycle_done` and never raises `flush_req`.
- R6: `halted` is never raised by the normal path while `hs_busy` is high or `sync_offset` is nonzero. The pulse comes one cycle after both are seen clear in the drain state.
- R7: With `activity` = 2'b10 (transfer control), the block waits for `tci_done`. If `tci_phase_jump` is high at that point, `ip_load` pulses for one cycle before the drain state is entered.
- R8: With `activity` = 2'b11 (other instruction), the instruction is cut off and the drain state is entered on the next clock.
- R9: When `bus_fault` is seen in the run state with a request, or in any wait or drain state, `halted` pulses on the next cycle. No fetch, flush or pointer step runs after that.
- R10: `halted` is a single-cycle pulse. The block then stays stopped while `irq_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Interrupt asks for a halt; held until serviced |
| irq_scsi | input | 1 | Interrupt comes from the SCSI side (low: DMA side) |
| activity | input | 2 | Activity in progress: 00 fetch, 01 transfer, 10 transfer control, 11 other |
| fetch_done | input | 1 | Current instruction fetch has completed |
| cycle_done | input | 1 | Current bus cycle has completed |
| tci_done | input | 1 | Transfer-control instruction has completed |
| tci_phase_jump | input | 1 | Completing instruction is a phase-testing jump or call |
| bus_fault | input | 1 | Bus fault reported by the memory side |
| dma_wr_mem | input | 1 | DMA direction is a write to memory |
| dma_fifo_empty | input | 1 | DMA FIFO holds no data |
| hs_busy | input | 1 | A SCSI request/acknowledge handshake is in progress |
| sync_offset | input | OFS_W | Outstanding synchronous offset count |
| flush_req | output | 1 | Request to flush the DMA FIFO to memory |
| ip_load | output | 1 | Strobe: load instruction pointer with transfer target |
| halted | output | 1 | One-cycle pulse: the halt is complete |
| exec_hold | output | 1 | Processor must not start a new instruction |

## Verification
A bus fault can arrive in the same cycle as a pending wait, such as a flush in progress or a transfer-control instruction still running. In that case the fault has to win over the completion the wait state is expecting. The bench raises `bus_fault` a random number of cycles before the completion signal would come. It then checks three things: `halted` appears exactly one cycle after the fault, `flush_req` was high only for the cycles before the fault, and `ip_load` never pulsed. The drain condition can also clear in the same cycle as the wait-state completion. Random drain lengths around the completion time probe this overlap, and the halt cycle is judged as the later of the two deadlines.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

    typedef enum logic [1:0] {
        ACT_FETCH = 2'b00,
        ACT_XFER  = 2'b01,
        ACT_TCI   = 2'b10,
        ACT_OTHER = 2'b11
    } act_e;

    typedef enum logic [3:0] {
        S_RUN,
        S_FETCH_WAIT,
        S_FLUSH,
        S_CYCLE_WAIT,
        S_TCI_WAIT,
        S_IP_LOAD,
        S_DRAIN,
        S_HALT,
        S_STOPPED
    } hstate_e;

endpackage

// File: rtl/halt_drain_check.sv
module halt_drain_check #(
    parameter int OFS_W = 5
) (
    input  logic             hs_busy,
    input  logic [OFS_W-1:0] sync_offset,
    output logic             drain_clear
);
    localparam logic [OFS_W-1:0] OFS_ZERO = '0;

    always_comb begin
        drain_clear = !hs_busy && (sync_offset == OFS_ZERO);
    end

endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
    import halt_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    irq_req,
    input  logic    irq_scsi,
    input  logic [1:0] activity,
    input  logic    fetch_done,
    input  logic    cycle_done,
    input  logic    tci_done,
    input  logic    tci_phase_jump,
    input  logic    bus_fault,
    input  logic    dma_wr_mem,
    input  logic    dma_fifo_empty,
    input  logic    drain_clear,
    output hstate_e state
);
    hstate_e state_nx;
    act_e    act;

    always_comb begin
        act = act_e'(activity);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_RUN: begin
                if (irq_req) begin
                    if (bus_fault) begin
                        state_nx = S_HALT;
                    end else begin
                        unique case (act)
                            ACT_FETCH: state_nx = S_FETCH_WAIT;
                            ACT_XFER:  state_nx = (irq_scsi && dma_wr_mem) ? S_FLUSH : S_CYCLE_WAIT;
                            ACT_TCI:   state_nx = S_TCI_WAIT;
                            ACT_OTHER: state_nx = S_DRAIN;
                        endcase
                    end
                end
            end
            S_FETCH_WAIT: begin
                if (bus_fault)       state_nx = S_HALT;
                else if (fetch_done) state_nx = S_DRAIN;
            end
            S_FLUSH: begin
                if (bus_fault)           state_nx = S_HALT;
                else if (dma_fifo_empty) state_nx = S_DRAIN;
            end
            S_CYCLE_WAIT: begin
                if (bus_fault)       state_nx = S_HALT;
                else if (cycle_done) state_nx = S_DRAIN;
            end
            S_TCI_WAIT: begin
                if (bus_fault)     state_nx = S_HALT;
                else if (tci_done) state_nx = tci_phase_jump ? S_IP_LOAD : S_DRAIN;
            end
            S_IP_LOAD: state_nx = S_DRAIN;
            S_DRAIN: begin
                if (bus_fault || drain_clear) state_nx = S_HALT;
            end
            S_HALT: state_nx = S_STOPPED;
            S_STOPPED: begin
                if (!irq_req) state_nx = S_RUN;
            end
            default: state_nx = S_RUN;
        endcase
    end

    AST_FAULT_TO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fault && (state inside {S_FETCH_WAIT, S_FLUSH, S_CYCLE_WAIT, S_TCI_WAIT, S_DRAIN}))
        |=> (state == S_HALT)); // R9

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOPPED && irq_req) |=> (state == S_STOPPED)); // R10

    AST_OTHER_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && irq_req && !bus_fault && activity == 2'b11) |=> (state == S_DRAIN)); // R8

endmodule

// File: rtl/halt_out.sv
module halt_out
    import halt_seq_pkg::*;
(
    input  hstate_e state,
    output logic    flush_req,
    output logic    ip_load,
    output logic    halted,
    output logic    exec_hold
);
    always_comb begin
        flush_req = 1'b0;
        ip_load   = 1'b0;
        halted    = 1'b0;
        exec_hold = 1'b1;
        unique case (state)
            S_RUN:     exec_hold = 1'b0;
            S_FLUSH:   flush_req = 1'b1;
            S_IP_LOAD: ip_load   = 1'b1;
            S_HALT:    halted    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/halt_seq.sv
module halt_seq
    import halt_seq_pkg::*;
#(
    parameter int OFS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic             irq_scsi,
    input  logic [1:0]       activity,
    input  logic             fetch_done,
    input  logic             cycle_done,
    input  logic             tci_done,
    input  logic             tci_phase_jump,
    input  logic             bus_fault,
    input  logic             dma_wr_mem,
    input  logic             dma_fifo_empty,
    input  logic             hs_busy,
    input  logic [OFS_W-1:0] sync_offset,
    output logic             flush_req,
    output logic             ip_load,
    output logic             halted,
    output logic             exec_hold
);
    logic    drain_clear;
    hstate_e state;

    halt_drain_check #(.OFS_W(OFS_W)) u_drain (
        .hs_busy     (hs_busy),
        .sync_offset (sync_offset),
        .drain_clear (drain_clear)
    );

    halt_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_req        (irq_req),
        .irq_scsi       (irq_scsi),
        .activity       (activity),
        .fetch_done     (fetch_done),
        .cycle_done     (cycle_done),
        .tci_done       (tci_done),
        .tci_phase_jump (tci_phase_jump),
        .bus_fault      (bus_fault),
        .dma_wr_mem     (dma_wr_mem),
        .dma_fifo_empty (dma_fifo_empty),
        .drain_clear    (drain_clear),
        .state          (state)
    );

    halt_out u_out (
        .state     (state),
        .flush_req (flush_req),
        .ip_load   (ip_load),
        .halted    (halted),
        .exec_hold (exec_hold)
    );

    AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !halted); // R10

    AST_HALT_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !$past(bus_fault)) |-> $past(!hs_busy && sync_offset == '0)); // R6

    AST_IPLOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |=> (!ip_load && !halted)); // R7

    AST_FLUSH_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> (!halted && exec_hold)); // R4

    AST_HOLD_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> exec_hold); // R2

endmodule

// File: tb/halt_seq_test.sv
module halt_seq_test;
    localparam int OFS_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 0, irq_scsi = 0, fetch_done = 0, cycle_done = 0, tci_done = 0;
    logic tci_phase_jump = 0, bus_fault = 0, dma_wr_mem = 0, dma_fifo_empty = 0, hs_busy = 0;
    logic [1:0] activity = 2'b11;
    logic [OFS_W-1:0] sync_offset = '0;
    logic flush_req, ip_load, halted, exec_hold;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #10 clk = ~clk;

    halt_seq #(.OFS_W(OFS_W)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_scsi(irq_scsi),
        .activity(activity), .fetch_done(fetch_done), .cycle_done(cycle_done),
        .tci_done(tci_done), .tci_phase_jump(tci_phase_jump), .bus_fault(bus_fault),
        .dma_wr_mem(dma_wr_mem), .dma_fifo_empty(dma_fifo_empty), .hs_busy(hs_busy),
        .sync_offset(sync_offset), .flush_req(flush_req), .ip_load(ip_load),
        .halted(halted), .exec_hold(exec_hold)
    );

    task automatic check(input string req, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic bit is_flush(input int act, input bit scsi, input bit wr);
        return (act == 1) && scsi && wr;
    endfunction

    // cycle (negedge index after the request) at which the drain state is entered
    function automatic int drain_entry(input int act, input bit jump, input int w);
        if (act == 3) return 1;
        return imax(2, w + 1) + ((act == 2 && jump) ? 1 : 0);
    endfunction

    function automatic int exp_halt(input int act, input bit jump, input int w,
                                    input int d, input int f);
        if (f >= 0) return f + 1;
        return imax(drain_entry(act, jump, w) + 1, d + 1);
    endfunction

    function automatic int exp_flush(input int act, input bit scsi, input bit wr,
                                     input int w, input int f);
        if (!is_flush(act, scsi, wr)) return 0;
        if (f >= 0) return f;
        return imax(1, w);
    endfunction

    task automatic run_case(input int act, input bit scsi, input bit wr, input bit jump,
                            input int w, input int d, input int f);
        int h_exp, fl_exp, ip_exp, h_seen, fl_cnt, ip_cnt;
        string tag;
        h_exp  = exp_halt(act, jump, w, d, f);
        fl_exp = exp_flush(act, scsi, wr, w, f);
        ip_exp = (act == 2 && jump && f < 0) ? 1 : 0;
        h_seen = -1; fl_cnt = 0; ip_cnt = 0;
        unique case (act)
            0: tag = "R3";
            1: tag = is_flush(act, scsi, wr) ? "R4" : "R5";
            2: tag = "R7";
            default: tag = "R8";
        endcase
        if (f >= 0) tag = "R9";
        @(negedge clk);
        activity = 2'(act); irq_scsi = scsi; dma_wr_mem = wr; tci_phase_jump = jump;
        fetch_done = 0; cycle_done = 0; tci_done = 0; dma_fifo_empty = 0;
        hs_busy = (d > 0); sync_offset = (d > 0) ? OFS_W'(d % 7 + 1) : '0;
        bus_fault = (f == 0);
        irq_req = 1;
        for (int t = 1; t <= h_exp + 1; t++) begin
            @(negedge clk);
            if (t == 1) check("R2 hold raised", exec_hold, 1);
            if (halted && h_seen < 0) h_seen = t;
            if (flush_req) fl_cnt++;
            if (ip_load) ip_cnt++;
            if (t == h_exp + 1) check("R10 halt pulse width", halted, 0);
            if (t == w) begin
                fetch_done = (act == 0); cycle_done = (act == 1);
                tci_done = (act == 2); dma_fifo_empty = 1;
            end
            if (t == d) begin hs_busy = 0; sync_offset = '0; end
            if (f > 0 && t == f) bus_fault = 1;
        end
        check({tag, " R6 halt cycle"}, h_seen, h_exp);
        check({tag, " flush cycles"}, fl_cnt, fl_exp);
        check({tag, " ip_load count"}, ip_cnt, ip_exp);
        bus_fault = 0; hs_busy = 0; sync_offset = '0;
        @(negedge clk);
        check("R10 stays stopped", exec_hold, 1);
        irq_req = 0;
        @(negedge clk);
        check("R2 hold released", exec_hold, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 flush_req", flush_req, 0);
        check("R1 ip_load", ip_load, 0);
        check("R1 halted", halted, 0);
        check("R1 exec_hold", exec_hold, 0);
        rst_n = 1;
        @(negedge clk);
        // directed corners
        run_case(3, 1, 1, 0, 1, 0, -1);   // R8 cut off, nothing to drain
        run_case(0, 0, 0, 0, 3, 0, -1);   // R3 fetch
        run_case(1, 1, 1, 0, 4, 0, -1);   // R4 flush
        run_case(1, 0, 1, 0, 2, 0, -1);   // R5 DMA interrupt, no flush
        run_case(1, 1, 0, 0, 2, 0, -1);   // R5 read direction, no flush
        run_case(2, 0, 0, 1, 3, 0, -1);   // R7 phase jump
        run_case(2, 0, 0, 0, 3, 0, -1);   // R7 plain TCI
        run_case(3, 0, 0, 0, 1, 6, -1);   // R6 drain wait
        run_case(1, 1, 1, 0, 5, 6, -1);   // R6 drain clears right after flush
        run_case(1, 1, 1, 0, 6, 0, 2);    // R9 fault during flush
        run_case(2, 0, 0, 1, 5, 0, 3);    // R9 fault beats phase jump
        run_case(0, 0, 0, 0, 3, 4, 0);    // R9 fault at acceptance
        // random mix
        for (int i = 0; i < 80; i++) begin
            int act, w, d, f;
            bit scsi, wr, jump;
            act  = int'($urandom_range(0, 3));
            scsi = 1'($urandom_range(0, 1));
            wr   = 1'($urandom_range(0, 1));
            jump = 1'($urandom_range(0, 1));
            w    = int'($urandom_range(1, 8));
            d    = int'($urandom_range(0, 10));
            f    = -1;
            if ($urandom_range(0, 4) == 0) begin
                if (act == 3 || w == 1) f = 0;
                else f = int'($urandom_range(0, w - 1));
            end
            run_case(act, scsi, wr, jump, w, d, f);
        end
        done_run = 1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule